// File: doc/BRIEF.md
# Segment-Coincidence Track Trigger

This block produces a fast track-trigger decision for one azimuthal wedge of a four-layer silicon strip tracker. For each event it receives one strip hit bitmap per layer. It reduces each bitmap to coarse segments by OR-ing fixed groups of neighbouring strips. The two outer layers use wide groups and the two middle layers use narrow groups. The hit segments are then compared with a table of track patterns. Each pattern names one segment on every layer.

A pattern accepts the event when its segments are hit on at least three of the four layers. The missing layer may be any layer except the innermost one: the innermost segment must always be hit. The wedge accept bit is the OR over all valid matching patterns. It is placed at the wedge's position in an 18-bit sector vector.

A start strobe latches the hit bitmaps and the sector number. The table is then scanned one entry per clock. A done pulse marks the end of the scan, and the result is held until the next accepted start. The pattern table is written through an address/data/write-enable port while no scan is running.

Top module: `seg_track_trigger`

## Requirements
- R1: On layers 1 and 4, strip s (0..511) belongs to segment s/32, giving 16 segments. A segment counts as hit when any of its 32 strips is hit.
- R2: On layers 2 and 3, strip s belongs to segment s/16, giving 32 segments. A segment counts as hit when any of its 16 strips is hit.
- R3: A valid pattern whose four segments are all hit makes the wedge accept.
- R4: A valid pattern matches when its layer-1 segment is hit and at least two of its layer-2/3/4 segments are hit. With fewer than three layers hit, the pattern does not match.
- R5: A pattern whose layer-1 segment is not hit never matches, even when its layer-2, layer-3 and layer-4 segments are all hit.
- R6: The accept result is the OR of all matching entries whose valid bit is 1. An entry with valid bit 0 never matches.
- R7: An accepted start raises busy for exactly 64 cycles while the 64 table entries are scanned. done is a one-cycle pulse in the cycle after the last entry is scanned. accept reads 0 while busy and otherwise holds the last result until the next accepted start.
- R8: A start strobe while busy is high is ignored. It does not change the scan length, the latched hits, the latched sector or the result.
- R9: cfg_data layout is bit 18 = valid, bits 17:14 = layer-1 segment, 13:9 = layer-2 segment, 8:4 = layer-3 segment, 3:0 = layer-4 segment. A write with cfg_we high while busy is low stores the entry at cfg_addr. A write while busy is high is discarded.
- R10: sector_vec equals accept shifted to bit position sector, as latched at the accepted start. It is all zero when sector is 18 or larger.
- R11: After reset, busy, done, accept and sector_vec are 0 and every table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start-of-event strobe |
| sector | input | 5 | Wedge number, latched at start |
| hits_l1 | input | 512 | Strip hits, layer 1 (innermost) |
| hits_l2 | input | 512 | Strip hits, layer 2 |
| hits_l3 | input | 512 | Strip hits, layer 3 |
| hits_l4 | input | 512 | Strip hits, layer 4 |
| cfg_we | input | 1 | Pattern table write enable |
| cfg_addr | input | 6 | Pattern table entry address |
| cfg_data | input | 19 | Pattern entry (layout in R9) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| accept | output | 1 | Wedge accept result |
| sector_vec | output | 18 | Accept bit at the wedge's sector position |

## Verification
Two events can collide with the end of a scan or with a running scan. A start strobe can coincide with the done pulse. A start or a table write can arrive while a scan is still running. The bench drives a second start exactly in the done cycle, which must begin a fresh scan. It also pulses start with new hits and a new sector in the middle of a scan, and writes a matching entry mid-scan. A behavioural reference model of busy, done, accept and sector_vec is advanced on every clock and compared in every cycle. It judges whether the collision was honoured or ignored.

// File: rtl/seg_track_trigger.sv
module seg_track_trigger #(
  parameter int STRIPS  = 512,
  parameter int GRP_OUT = 32,
  parameter int GRP_MID = 16,
  parameter int DEPTH   = 64,
  parameter int NSECT   = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [4:0]        sector,
  input  logic [STRIPS-1:0] hits_l1,
  input  logic [STRIPS-1:0] hits_l2,
  input  logic [STRIPS-1:0] hits_l3,
  input  logic [STRIPS-1:0] hits_l4,
  input  logic              cfg_we,
  input  logic [5:0]        cfg_addr,
  input  logic [18:0]       cfg_data,
  output logic              busy,
  output logic              done,
  output logic              accept,
  output logic [NSECT-1:0]  sector_vec
);
  localparam int SEG_OUT = STRIPS / GRP_OUT;
  localparam int SEG_MID = STRIPS / GRP_MID;
  localparam int WO = $clog2(SEG_OUT);
  localparam int WM = $clog2(SEG_MID);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = 1 + 2*WO + 2*WM;

  logic [EW-1:0] tab [DEPTH];
  logic [SEG_OUT-1:0] s1_w, s4_w, s1_q, s4_q;
  logic [SEG_MID-1:0] s2_w, s3_w, s2_q, s3_q;
  logic [AW-1:0] idx;
  logic [4:0] sec_q;
  logic acc;

  for (genvar g = 0; g < SEG_OUT; g++) begin : g_outer
    assign s1_w[g] = |hits_l1[g*GRP_OUT +: GRP_OUT];
    assign s4_w[g] = |hits_l4[g*GRP_OUT +: GRP_OUT];
  end
  for (genvar g = 0; g < SEG_MID; g++) begin : g_middle
    assign s2_w[g] = |hits_l2[g*GRP_MID +: GRP_MID];
    assign s3_w[g] = |hits_l3[g*GRP_MID +: GRP_MID];
  end

  wire [EW-1:0] ent  = tab[idx];
  wire          ev   = ent[EW-1];
  wire [WO-1:0] f1   = ent[EW-2 -: WO];
  wire [WM-1:0] f2   = ent[EW-2-WO -: WM];
  wire [WM-1:0] f3   = ent[EW-2-WO-WM -: WM];
  wire [WO-1:0] f4   = ent[WO-1:0];
  wire h1 = s1_q[f1];
  wire h2 = s2_q[f2];
  wire h3 = s3_q[f3];
  wire h4 = s4_q[f4];
  wire match = ev & h1 & ((h2 & h3) | (h2 & h4) | (h3 & h4));
  wire last  = (idx == AW'(DEPTH-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tab[i] <= '0;
    end else if (cfg_we && !busy) begin
      tab[cfg_addr[AW-1:0]] <= cfg_data[EW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      acc  <= 1'b0;
      idx  <= '0;
      sec_q <= '0;
      s1_q <= '0; s2_q <= '0; s3_q <= '0; s4_q <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        acc <= acc | match;
        idx <= idx + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        busy  <= 1'b1;
        acc   <= 1'b0;
        idx   <= '0;
        sec_q <= sector;
        s1_q <= s1_w; s2_q <= s2_w; s3_q <= s3_w; s4_q <= s4_w;
      end
    end
  end

  assign accept = acc & ~busy;
  for (genvar g = 0; g < NSECT; g++) begin : g_sect
    assign sector_vec[g] = accept & (sec_q == 5'(g));
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(accept) && $stable(sector_vec));
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy && $stable(sec_q) && $stable(s1_q));
  p_l1_veto_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !h1) |=> $stable(acc));
  p_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ev) |=> $stable(acc));
  p_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we) |=> tab[$past(cfg_addr[AW-1:0])] == $past(tab[cfg_addr[AW-1:0]]));
  p_sector_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sector_vec));
endmodule

// File: tb/seg_track_trigger_tb_top.sv
module seg_track_trigger_tb_top;
  logic clk = 0, rst_n = 0, start = 0, cfg_we = 0;
  logic [4:0] sector = 0;
  logic [511:0] hits_l1 = '0, hits_l2 = '0, hits_l3 = '0, hits_l4 = '0;
  logic [5:0] cfg_addr = 0;
  logic [18:0] cfg_data = 0;
  logic busy, done, accept;
  logic [17:0] sector_vec;
  int tests = 0, fails = 0;
  string cur_tag = "R7";

  always #10 clk = ~clk;

  seg_track_trigger dut_i (.clk(clk), .rst_n(rst_n), .start(start), .sector(sector),
    .hits_l1(hits_l1), .hits_l2(hits_l2), .hits_l3(hits_l3), .hits_l4(hits_l4),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .busy(busy), .done(done), .accept(accept), .sector_vec(sector_vec));

  // reference model
  int mv[64], m1[64], m2[64], m3[64], m4[64];
  logic [511:0] q1, q2, q3, q4;
  bit m_busy = 0, m_done = 0, m_acc = 0;
  int m_cnt = 0, m_sec = 0;

  function automatic bit seg_hit(logic [511:0] h, int seg, int grp);
    for (int k = 0; k < grp; k++) if (h[seg*grp + k]) return 1;
    return 0;
  endfunction

  function automatic bit ref_eval();
    for (int e = 0; e < 64; e++) begin
      int n;
      bit a;
      if (mv[e] == 0) continue;
      a = seg_hit(q1, m1[e], 32);
      n = a + seg_hit(q2, m2[e], 16) + seg_hit(q3, m3[e], 16) + seg_hit(q4, m4[e], 32);
      if (a && n >= 3) return 1;
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_acc <= 0; m_cnt <= 0; m_sec <= 0;
      for (int e = 0; e < 64; e++) mv[e] = 0;
    end else begin
      m_done <= 0;
      if (m_busy) begin
        if (m_cnt == 63) begin
          m_busy <= 0; m_done <= 1; m_acc <= ref_eval();
        end
        m_cnt <= m_cnt + 1;
      end else begin
        if (cfg_we) begin
          mv[cfg_addr] = cfg_data[18]; m1[cfg_addr] = cfg_data[17:14];
          m2[cfg_addr] = cfg_data[13:9]; m3[cfg_addr] = cfg_data[8:4];
          m4[cfg_addr] = cfg_data[3:0];
        end
        if (start) begin
          m_busy <= 1; m_cnt <= 0; m_acc <= 0; m_sec <= sector;
          q1 <= hits_l1; q2 <= hits_l2; q3 <= hits_l3; q4 <= hits_l4;
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit ea;
    logic [17:0] ev;
    ea = m_busy ? 1'b0 : m_acc;
    ev = (ea && m_sec < 18) ? (18'd1 << m_sec) : 18'd0;
    chk(busy == m_busy, "R7 busy", busy, m_busy);
    chk(done == m_done, "R7 done", done, m_done);
    chk(accept == ea, cur_tag, accept, ea);
    chk(sector_vec == ev, "R10", sector_vec, ev);
  end

  task automatic wr(int a, bit v, int s1, int s2, int s3, int s4);
    cfg_we = 1; cfg_addr = 6'(a);
    cfg_data = {v, 4'(s1), 5'(s2), 5'(s3), 4'(s4)};
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clr();
    hits_l1 = '0; hits_l2 = '0; hits_l3 = '0; hits_l4 = '0;
  endtask

  task automatic run(string tag, int sec, bit exp, bit settle = 1);
    logic [17:0] ev;
    cur_tag = tag; sector = 5'(sec); start = 1;
    @(negedge clk);
    start = 0;
    repeat (64) @(negedge clk);
    ev = (exp && sec < 18) ? (18'd1 << sec) : 18'd0;
    chk(done == 1, "R7 done end", done, 1);
    chk(accept == exp, tag, accept, exp);
    chk(sector_vec == ev, "R10 vec", sector_vec, ev);
    if (settle) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && accept == 0 && sector_vec == 0, "R11",
        {busy, done, accept}, 0);

    wr(5, 1, 3, 10, 20, 7);
    wr(9, 0, 0, 0, 0, 0);

    clr(); hits_l1[127] = 1; hits_l2[160] = 1; hits_l3[335] = 1; hits_l4[224] = 1;
    run("R3 R1 R2 four layers", 4, 1);
    hits_l3 = '0;
    run("R4 layer3 missing", 4, 1);
    clr(); hits_l2[160] = 1; hits_l3[335] = 1; hits_l4[224] = 1;
    run("R5 layer1 missing", 4, 0);
    hits_l1[128] = 1;
    run("R1 neighbour segment", 4, 0);
    clr(); hits_l1[100] = 1; hits_l2[176] = 1; hits_l4[255] = 1;
    run("R2 neighbour segment", 4, 0);
    clr(); hits_l1[96] = 1; hits_l2[175] = 1;
    run("R4 two layers only", 4, 0);

    clr(); hits_l1[0] = 1; hits_l2[0] = 1; hits_l3[0] = 1; hits_l4[0] = 1;
    run("R6 invalid entry", 1, 0);
    wr(9, 1, 0, 0, 0, 0);
    run("R6 entry made valid", 0, 1);

    // R8: start mid-scan with other hits and sector
    clr(); hits_l1[127] = 1; hits_l2[160] = 1; hits_l4[224] = 1;
    cur_tag = "R8 start ignored"; sector = 2; start = 1;
    @(negedge clk);
    start = 0; clr();
    repeat (10) @(negedge clk);
    sector = 7; start = 1;
    @(negedge clk);
    start = 0;
    repeat (53) @(negedge clk);
    chk(done == 1, "R8 scan length", done, 1);
    chk(accept == 1 && sector_vec == 18'd4, "R8 result", sector_vec, 18'd4);
    @(negedge clk);

    // R9: write during scan discarded
    clr(); hits_l1[511] = 1; hits_l2[511] = 1; hits_l3[511] = 1; hits_l4[511] = 1;
    cur_tag = "R9 write busy"; sector = 3; start = 1;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    wr(12, 1, 15, 31, 31, 15);
    repeat (58) @(negedge clk);
    chk(done == 1 && accept == 0, "R9 scan", accept, 0);
    @(negedge clk);
    run("R9 write busy discarded", 3, 0);
    wr(12, 1, 15, 31, 31, 15);
    run("R9 write idle stored", 17, 1, 0);

    // R7: start in the done cycle begins a new scan
    clr();
    run("R7 back to back start", 6, 0);
    run("R10 out of range sector", 20, 0);
    hits_l1[511] = 1; hits_l2[500] = 1; hits_l4[480] = 1;
    run("R10 out of range sector", 20, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule